// File: doc/BRIEF.md
# CSR Access and Permission Unit

This block carries out control/status register access operations for a processor core against a small built-in bank of registers: a swap, a bit-set, a bit-clear, a write with no destination result, and a read with no write. Each request is checked against the current privilege mode before anything happens. The required level is taken from the register address. A supervisor-mode access to the address-translation register is refused while the trap-virtual-memory control bit is set. A refused access changes no register and produces no destination value.

The register is read and written in the same cycle the request is presented. The response is held in registers and appears one clock later: the old value with a destination-write strobe, an illegal-instruction flag, or an error flag when the address names no register in the bank. The pipeline stage that issues the request routes the returned value to the destination register. It also raises the exception when either flag is set.

Top module: `csr_access_unit`

## Requirements
- R1: The minimum privilege of an access is the address field at bits 9:8. Privilege is encoded as 0 user, 1 supervisor and 3 machine. When the current mode is numerically lower than that field, the response has `rsp_trap`=1 and `rsp_rd_we`=0, and no register changes.
- R2: When the current mode is supervisor (1), the address is 0x180 and `tvm`=1, the access traps as in R1. The same access in machine mode (3), or with `tvm`=0, proceeds normally.
- R3: Operation code 0 (swap) returns the old value with `rsp_rd_we`=1 and writes the source operand in full.
- R4: Operation code 1 (set) returns the old value and writes the old value OR the source.
- R5: Operation code 2 (clear) returns the old value and writes the old value AND NOT the source.
- R6: Operation code 3 (write-only) writes the source operand. The response has `rsp_rd_we`=0 and `rsp_rdata`=0.
- R7: Operation code 4 (read-only) returns the current value and leaves the register unchanged. Codes 5 to 7 behave exactly as code 4.
- R8: Three registers are implemented: address-translation at 0x180, machine scratch at 0x340 and user scratch at 0x040. A privileged-enough access to any other address gives `rsp_addr_err`=1 and `rsp_rd_we`=0, and changes no register. A trap takes precedence, so at most one of `rsp_trap`, `rsp_addr_err` and `rsp_rd_we` is set.
- R9: The response for a request sampled at a clock edge is visible after that edge with `rsp_valid`=1. A request in the next cycle sees the value just written. A cycle without `req_valid` gives `rsp_valid`=0 with all flags and data 0, and changes no register.
- R10: After reset all three registers read 0 and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 swap, 1 set, 2 clear, 3 write-only, 4 read-only) |
| req_addr | input | 12 | Register address |
| req_src | input | XLEN | Source operand |
| cur_priv | input | 2 | Current privilege mode |
| tvm | input | 1 | Trap-virtual-memory control bit |
| rsp_valid | output | 1 | Response present |
| rsp_rd_we | output | 1 | Destination write strobe |
| rsp_rdata | output | XLEN | Old register value for the destination |
| rsp_trap | output | 1 | Illegal-instruction trap |
| rsp_addr_err | output | 1 | Address names no implemented register |

## Verification
The bench builds the unit with XLEN=64. Random operands therefore set and clear bits in the upper word, so a truncated data path or a narrowed mask shows up in the returned old values. The privilege modes and the address set are drawn together. This reaches every pairing of mode and address level, the address-translation rule with both values of the control bit, and unimplemented addresses at each level. Back-to-back requests to the same register expose write-to-read forwarding errors.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

   localparam int ADDR_W  = 12;
   localparam int PRIV_W  = 2;
   localparam int NUM_CSR = 3;

   typedef enum logic [2:0] {
      OP_SWAP   = 3'd0,
      OP_SET    = 3'd1,
      OP_CLR    = 3'd2,
      OP_WRONLY = 3'd3,
      OP_RDONLY = 3'd4
   } csr_op_e;

   localparam logic [PRIV_W-1:0] PRIV_U = 2'd0;
   localparam logic [PRIV_W-1:0] PRIV_S = 2'd1;
   localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;

   localparam logic [ADDR_W-1:0] ADDR_XLAT  = 12'h180;
   localparam logic [ADDR_W-1:0] ADDR_MSCR  = 12'h340;
   localparam logic [ADDR_W-1:0] ADDR_USCR  = 12'h040;

   localparam logic [ADDR_W-1:0] CSR_ADDRS [NUM_CSR] = '{ADDR_XLAT, ADDR_MSCR, ADDR_USCR};

endpackage

// File: rtl/csr_priv_gate.sv
module csr_priv_gate
   import csr_unit_pkg::*;
#(
   parameter int LVL_LO = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [PRIV_W-1:0] priv,
   input  logic              tvm,
   output logic              illegal
);
   localparam int LVL_HI = LVL_LO + PRIV_W - 1;

   logic [PRIV_W-1:0] need_lvl;
   logic              too_low;
   logic              xlat_block;

   always_comb begin
      need_lvl   = addr[LVL_HI:LVL_LO];
      too_low    = priv < need_lvl;
      xlat_block = (priv == PRIV_S) && (addr == ADDR_XLAT) && tvm;
      illegal    = too_low || xlat_block;
   end
endmodule

// File: rtl/csr_rmw.sv
module csr_rmw
   import csr_unit_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [2:0]      op,
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] src,
   output logic [XLEN-1:0] new_val,
   output logic            wr_op,
   output logic            rd_op
);
   always_comb begin
      new_val = old_val;
      wr_op   = 1'b0;
      rd_op   = 1'b1;
      case (op)
         OP_SWAP:   begin new_val = src;              wr_op = 1'b1; end
         OP_SET:    begin new_val = old_val | src;    wr_op = 1'b1; end
         OP_CLR:    begin new_val = old_val & ~src;   wr_op = 1'b1; end
         OP_WRONLY: begin new_val = src;              wr_op = 1'b1; rd_op = 1'b0; end
         default:   begin new_val = old_val;          wr_op = 1'b0; end
      endcase
   end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
   import csr_unit_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int NREG = NUM_CSR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [XLEN-1:0]   wdata,
   output logic              hit,
   output logic [XLEN-1:0]   rdata
);
   logic [NREG-1:0]  sel;
   logic [XLEN-1:0]  q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      assign sel[g] = (addr == CSR_ADDRS[g]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            q[g] <= '0;
         else if (we && sel[g]) q[g] <= wdata;
      end

      // R9: a register not selected for a write keeps its value
      a_r9_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && sel[g]) |=> $stable(q[g]));
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++)
         if (sel[i]) rdata = rdata | q[i];
      hit = |sel;
   end

   a_r8_decode_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
   import csr_unit_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [11:0]       req_addr,
   input  logic [XLEN-1:0]   req_src,
   input  logic [1:0]        cur_priv,
   input  logic              tvm,
   output logic              rsp_valid,
   output logic              rsp_rd_we,
   output logic [XLEN-1:0]   rsp_rdata,
   output logic              rsp_trap,
   output logic              rsp_addr_err
);
   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("csr_access_unit: XLEN must be 32 or 64");
   end

   logic            illegal;
   logic            hit;
   logic [XLEN-1:0] old_val;
   logic [XLEN-1:0] new_val;
   logic            wr_op;
   logic            rd_op;
   logic            granted;
   logic            do_write;
   logic            do_read;

   csr_priv_gate u_gate (
      .addr    (req_addr),
      .priv    (cur_priv),
      .tvm     (tvm),
      .illegal (illegal)
   );

   csr_rmw #(.XLEN(XLEN)) u_rmw (
      .op      (req_op),
      .old_val (old_val),
      .src     (req_src),
      .new_val (new_val),
      .wr_op   (wr_op),
      .rd_op   (rd_op)
   );

   csr_bank #(.XLEN(XLEN)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (req_addr),
      .we    (do_write),
      .wdata (new_val),
      .hit   (hit),
      .rdata (old_val)
   );

   always_comb begin
      granted  = req_valid && !illegal;
      do_write = granted && hit && wr_op;
      do_read  = granted && hit && rd_op;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_rd_we    <= 1'b0;
         rsp_rdata    <= '0;
         rsp_trap     <= 1'b0;
         rsp_addr_err <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_trap     <= req_valid && illegal;
         rsp_addr_err <= granted && !hit;
         rsp_rd_we    <= do_read;
         rsp_rdata    <= do_read ? old_val : '0;
      end
   end

   a_r1_low_priv_traps: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (cur_priv < req_addr[9:8]) |=> rsp_trap && !rsp_rd_we);

   a_r2_xlat_tvm_traps: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && cur_priv == PRIV_S && req_addr == ADDR_XLAT && tvm |=> rsp_trap);

   a_r6_wronly_no_dest: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_op == OP_WRONLY |=> !rsp_rd_we && rsp_rdata == '0);

   a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_trap, rsp_addr_err, rsp_rd_we}));

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_trap && !rsp_addr_err && !rsp_rd_we);
endmodule

// File: tb/csr_access_unit_tb.sv
`timescale 1ns/1ps
module csr_access_unit_tb_top;
   localparam int W = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [2:0]   req_op = '0;
   logic [11:0]  req_addr = '0;
   logic [W-1:0] req_src = '0;
   logic [1:0]   cur_priv = '0;
   logic         tvm = 1'b0;
   logic         rsp_valid, rsp_rd_we, rsp_trap, rsp_addr_err;
   logic [W-1:0] rsp_rdata;

   int n_checks = 0;
   int n_errors = 0;
   logic [W-1:0] model [3];

   always #2.5 clk = ~clk;

   csr_access_unit #(.XLEN(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_src(req_src), .cur_priv(cur_priv), .tvm(tvm),
      .rsp_valid(rsp_valid), .rsp_rd_we(rsp_rd_we), .rsp_rdata(rsp_rdata),
      .rsp_trap(rsp_trap), .rsp_addr_err(rsp_addr_err)
   );

   task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int reg_idx(logic [11:0] a);
      if (a == 12'h180) return 0;
      if (a == 12'h340) return 1;
      if (a == 12'h040) return 2;
      return -1;
   endfunction

   function automatic logic is_illegal(logic [11:0] a, logic [1:0] p, logic t);
      return (p < a[9:8]) || (p == 2'd1 && a == 12'h180 && t);
   endfunction

   function automatic logic [W-1:0] next_val(logic [2:0] op, logic [W-1:0] o, logic [W-1:0] s);
      case (op)
         3'd0, 3'd3: return s;
         3'd1:       return o | s;
         3'd2:       return o & ~s;
         default:    return o;
      endcase
   endfunction

   // Issue one request at a negedge, check the response at the following negedge.
   task automatic do_req(logic [2:0] op, logic [11:0] a, logic [W-1:0] s,
                         logic [1:0] p, logic t, string tag);
      int           ix;
      logic         ill;
      logic         ew, ee, et;
      logic [W-1:0] ed;
      req_valid = 1'b1; req_op = op; req_addr = a; req_src = s; cur_priv = p; tvm = t;
      ix  = reg_idx(a);
      ill = is_illegal(a, p, t);
      et  = ill;
      ee  = !ill && ix < 0;
      ew  = !ill && ix >= 0 && op != 3'd3;
      ed  = ew ? model[ix] : '0;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "valid", W'(rsp_valid), W'(1'b1));
      chk(tag, "trap", W'(rsp_trap), W'(et));
      chk(tag, "addr_err", W'(rsp_addr_err), W'(ee));
      chk(tag, "rd_we", W'(rsp_rd_we), W'(ew));
      chk(tag, "rdata", rsp_rdata, ed);
      if (!ill && ix >= 0) model[ix] = next_val(op, model[ix], s);
      req_valid = 1'b0;
   endtask

   task automatic peek(int ix, string tag);
      logic [11:0] a;
      a = (ix == 0) ? 12'h180 : (ix == 1) ? 12'h340 : 12'h040;
      do_req(3'd4, a, '0, 2'd3, 1'b0, tag);
   endtask

   function automatic logic [W-1:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   initial begin
      #(200000 * 5);
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [11:0] addrs [8];
      logic [1:0]  privs [3];
      string       tg;
      void'($urandom(32'd2024));
      addrs = '{12'h180, 12'h340, 12'h040, 12'h140, 12'h300, 12'h000, 12'h380, 12'h181};
      privs = '{2'd0, 2'd1, 2'd3};
      for (int i = 0; i < 3; i++) model[i] = '0;

      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "valid", W'(rsp_valid), '0);
      chk("R10", "rdata", rsp_rdata, '0);
      chk("R10", "trap", W'(rsp_trap), '0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 3; i++) peek(i, "R10");

      // R3 swap, R4 set, R5 clear on the machine scratch
      do_req(3'd0, 12'h340, 64'hF0F0_0000_1234_5678, 2'd3, 1'b0, "R3");
      do_req(3'd1, 12'h340, 64'h0F00_0000_0000_0001, 2'd3, 1'b0, "R4");
      do_req(3'd2, 12'h340, 64'hF000_0000_0000_0008, 2'd3, 1'b0, "R5");
      peek(1, "R5");
      // R6 write-only then read back
      do_req(3'd3, 12'h040, 64'hDEAD_BEEF_CAFE_0001, 2'd0, 1'b0, "R6");
      peek(2, "R6");
      // R7 read-only and undefined codes leave value
      for (int c = 4; c < 8; c++) do_req(3'(c), 12'h040, rnd64(), 2'd0, 1'b0, "R7");
      peek(2, "R7");
      // R1 user to machine and supervisor registers
      do_req(3'd0, 12'h340, rnd64(), 2'd0, 1'b0, "R1");
      do_req(3'd0, 12'h180, rnd64(), 2'd0, 1'b0, "R1");
      do_req(3'd0, 12'h340, rnd64(), 2'd1, 1'b0, "R1");
      peek(1, "R1");
      // R2 translation register with tvm in each mode
      do_req(3'd0, 12'h180, 64'h8000_0000_0000_00AA, 2'd1, 1'b1, "R2");
      peek(0, "R2");
      do_req(3'd0, 12'h180, 64'h8000_0000_0000_00BB, 2'd1, 1'b0, "R2");
      do_req(3'd1, 12'h180, 64'h0000_0000_0000_0100, 2'd3, 1'b1, "R2");
      peek(0, "R2");
      // R8 unimplemented addresses
      do_req(3'd0, 12'h300, rnd64(), 2'd3, 1'b0, "R8");
      do_req(3'd3, 12'h000, rnd64(), 2'd0, 1'b0, "R8");
      do_req(3'd0, 12'h380, rnd64(), 2'd1, 1'b0, "R8");
      // R9 idle cycle: no response, no change
      req_valid = 1'b0; req_op = 3'd0; req_addr = 12'h340; req_src = '1; cur_priv = 2'd3;
      @(posedge clk); @(negedge clk);
      chk("R9", "idle valid", W'(rsp_valid), '0);
      chk("R9", "idle rd_we", W'(rsp_rd_we), '0);
      chk("R9", "idle rdata", rsp_rdata, '0);
      peek(1, "R9");
      // R9 back-to-back forwarding
      do_req(3'd0, 12'h040, 64'h1111_2222_3333_4444, 2'd0, 1'b0, "R9");
      do_req(3'd1, 12'h040, 64'h0000_0000_0000_8000, 2'd0, 1'b0, "R9");
      peek(2, "R9");

      // Random mix
      for (int k = 0; k < 600; k++) begin
         logic [2:0]  op;
         logic [11:0] a;
         logic [1:0]  p;
         logic        t;
         op = 3'($urandom_range(0, 7));
         a  = addrs[$urandom_range(0, 7)];
         p  = privs[$urandom_range(0, 2)];
         t  = 1'($urandom_range(0, 1));
         if (is_illegal(a, p, t)) tg = (p < a[9:8]) ? "R1" : "R2";
         else if (reg_idx(a) < 0) tg = "R8";
         else case (op)
            3'd0: tg = "R3";
            3'd1: tg = "R4";
            3'd2: tg = "R5";
            3'd3: tg = "R6";
            default: tg = "R7";
         endcase
         do_req(op, a, rnd64(), p, t, tg);
         if ($urandom_range(0, 7) == 0) begin
            @(posedge clk); @(negedge clk);
            chk("R9", "gap valid", W'(rsp_valid), '0);
         end
      end

      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule